// File: doc/BRIEF.md
# Ethernet Transmit Error Sequencer

This block sits beside the transmit data path of an Ethernet MAC whose frames are built from one or more buffer descriptors. It starts each frame when a descriptor is waiting, watches the nibble stream heading for the PHY, and reacts to three error inputs: FIFO underrun, collision, and retries used up. An underrun replaces the rest of the frame with a 32-bit corrupting tail. A late collision, or a collision after the retry budget is spent, cuts the frame off at once. After any abort, the block closes every remaining descriptor of the frame without sending it. It then starts the next frame on its own.

A collision inside the slot window asks the backoff logic for a retry and counts it. The slot window is 128 nibble periods of enable, counted from the first preamble nibble. Three sticky event bits record the abort kinds. A mask selects which of them drive the interrupt line. When the MAC is set up for internal loopback, the block holds the external enable and error pins low.

Top module: `txs_err_seq`

## Requirements
- R1: After reset the sequencer is idle, all event bits are 0, and `irq`, `txen_out`, `txer_out`, `close_v`, `tx_start` and `retry_req` are 0 whenever no descriptor is waiting.
- R2: While idle, `tx_start` is high in every cycle that `desc_valid` is high, and the sequencer moves to sending on that edge.
- R3: While sending, a `desc_sent` pulse with no underrun or collision in the same cycle raises `close_v` for that cycle, carrying `desc_idx` and `desc_eof`. If `desc_eof` is 1, the sequencer returns to idle.
- R4: An underrun while sending sets event bit 0 (UN). The sequencer then drives `txen_out`=1, `txer_out`=1 and `txd_out`=`TAIL_NIBBLE` (default 4'hF) until `TAIL_NIB` (default 8) `nib_tick` pulses have passed, which is 32 bits. After that it enters flush.
- R5: In flush, every cycle with `desc_valid` high closes the head descriptor, which is the aborted frame's next descriptor. A closing descriptor with `desc_eof`=1 returns the sequencer to idle. `txen_out` and `txer_out` stay 0 throughout flush.
- R6: A collision while sending, before the slot counter reaches `SLOT_NIB` (128), raises `retry_req` for one cycle and increments the retry count, unless R7 applies. The slot counter advances on each `nib_tick` with `txen_in` high while sending. It restarts on `tx_start` and on each retry.
- R7: A collision inside the slot window when the retry count already equals `retry_max` sets event bit 2 (RL) and enters flush. So `retry_max` retries are allowed per frame.
- R8: A collision once the slot counter has reached 128 sets event bit 1 (LC) and enters flush, with no retry.
- R9: Within one sending cycle, underrun outranks collision, and collision outranks `desc_sent`. An abort or retry in the same cycle as `desc_sent` closes nothing.
- R10: `fifo_underrun` and `col_in` have no effect while idle, in the tail or in flush. Each frame attempt therefore records at most one abort event.
- R11: Event bits are sticky and clear when a 1 is written to the same position of `evt_clr`. A new event in the same cycle as its clear leaves the bit set.
- R12: `irq` is high exactly when some event bit and the matching `evt_mask` bit are both 1.
- R13: With `cfg_fdx`=1, `cfg_loop`=1 and `cfg_drt`=0, `txen_out` and `txer_out` are 0 in every state, including the tail. Any other setting leaves them ungated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_fdx | input | 1 | Full-duplex enable |
| cfg_loop | input | 1 | Loopback select |
| cfg_drt | input | 1 | Receive-while-transmit disable |
| retry_max | input | RW | Retries allowed per frame |
| nib_tick | input | 1 | One pulse per MII nibble period |
| txd_in | input | 4 | Nibble from the data path |
| txen_in | input | 1 | Enable from the data path |
| txer_in | input | 1 | Error from the data path |
| fifo_underrun | input | 1 | Transmit FIFO ran dry |
| col_in | input | 1 | Collision seen |
| desc_valid | input | 1 | A head descriptor is present |
| desc_idx | input | IDXW | Index of the head descriptor |
| desc_eof | input | 1 | Head descriptor ends its frame |
| desc_sent | input | 1 | Head descriptor's data fully sent |
| evt_clr | input | 3 | Write-1-to-clear strobe for the event bits |
| evt_mask | input | 3 | Interrupt mask |
| tx_start | output | 1 | Start a new frame |
| retry_req | output | 1 | Ask backoff logic for a retry |
| close_v | output | 1 | Close the head descriptor this cycle |
| close_idx | output | IDXW | Index being closed |
| close_last | output | 1 | Closed descriptor ends its frame |
| txd_out | output | 4 | Nibble to the PHY |
| txen_out | output | 1 | Enable to the PHY |
| txer_out | output | 1 | Error to the PHY |
| evt | output | 3 | Event bits: 0 UN, 1 LC, 2 RL |
| irq | output | 1 | Masked interrupt |

## Verification
The bench checks collisions on both sides of nibble 128. A design with an off-by-one slot window would record LC where a retry is due, or the reverse. It spends the whole retry budget to find out whether the RL abort comes one collision early or late. It fires underrun and collision together, and it injects errors during the tail and the flush. A design with the wrong priority, or one that re-arms during recovery, would then set two event bits or restart the tail. It also clears an event bit in the very cycle the event happens again, and it runs a tail inside internal loopback. Those cases expose a lost sticky bit and an enable pin that leaks to the PHY.

// File: rtl/txs_pkg.sv
package txs_pkg;
  typedef enum logic [1:0] {S_IDLE, S_SEND, S_TAIL, S_FLUSH} seq_state_e;

  localparam int EV_UN = 0;
  localparam int EV_LC = 1;
  localparam int EV_RL = 2;
  localparam int NEV   = 3;

  // Internal loopback keeps the PHY pins quiet.
  function automatic logic int_loop(input logic fdx, input logic lp, input logic drt);
    return fdx & lp & ~drt;
  endfunction

  // A collision is late once the slot count has reached the window size.
  function automatic logic slot_passed(input int unsigned cnt, input int unsigned win);
    return cnt >= win;
  endfunction

  // Sticky write-1-to-clear update; a fresh event wins over its clear.
  function automatic logic [NEV-1:0] evt_next(input logic [NEV-1:0] cur,
                                              input logic [NEV-1:0] clr,
                                              input logic [NEV-1:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/txs_slot_retry.sv
module txs_slot_retry #(
  parameter int SLOT_NIB = 128,
  parameter int RW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          retry,
  input  logic          count_en,
  output logic          late,
  output logic [RW-1:0] retry_cnt
);
  localparam int SW = $clog2(SLOT_NIB + 1);
  localparam logic [SW-1:0] SLOT_TOP = SW'(SLOT_NIB);

  logic [SW-1:0] slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q    <= '0;
      retry_cnt <= '0;
    end else begin
      if (restart || retry)
        slot_q <= '0;
      else if (count_en && slot_q != SLOT_TOP)
        slot_q <= slot_q + 1'b1;
      if (restart)
        retry_cnt <= '0;
      else if (retry)
        retry_cnt <= retry_cnt + 1'b1;
    end
  end

  assign late = txs_pkg::slot_passed(32'(slot_q), SLOT_NIB);
endmodule

// File: rtl/txs_tail_timer.sv
module txs_tail_timer #(
  parameter int TAIL_NIB = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int TW = (TAIL_NIB > 1) ? $clog2(TAIL_NIB) : 1;
  localparam logic [TW-1:0] LAST = TW'(TAIL_NIB - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (tick)     cnt_q <= cnt_q + 1'b1;
  end

  assign done = run & tick & (cnt_q == LAST);
endmodule

// File: rtl/txs_event_reg.sv
module txs_event_reg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] evt,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt <= '0;
    else        evt <= txs_pkg::evt_next(evt, clr, set);
  end

  assign irq = |(evt & mask);
endmodule

// File: rtl/txs_err_seq.sv
module txs_err_seq
  import txs_pkg::*;
#(
  parameter int         IDXW        = 4,
  parameter int         SLOT_NIB    = 128,
  parameter int         TAIL_NIB    = 8,
  parameter int         RW          = 4,
  parameter logic [3:0] TAIL_NIBBLE = 4'hF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_fdx,
  input  logic            cfg_loop,
  input  logic            cfg_drt,
  input  logic [RW-1:0]   retry_max,
  input  logic            nib_tick,
  input  logic [3:0]      txd_in,
  input  logic            txen_in,
  input  logic            txer_in,
  input  logic            fifo_underrun,
  input  logic            col_in,
  input  logic            desc_valid,
  input  logic [IDXW-1:0] desc_idx,
  input  logic            desc_eof,
  input  logic            desc_sent,
  input  logic [2:0]      evt_clr,
  input  logic [2:0]      evt_mask,
  output logic            tx_start,
  output logic            retry_req,
  output logic            close_v,
  output logic [IDXW-1:0] close_idx,
  output logic            close_last,
  output logic [3:0]      txd_out,
  output logic            txen_out,
  output logic            txer_out,
  output logic [2:0]      evt,
  output logic            irq
);
  seq_state_e    state_q, state_d;
  logic          in_send, in_tail, in_flush;
  logic          late, tail_done, lb;
  logic          col_hit, budget_gone;
  logic          un_evt, lc_evt, rl_evt;
  logic          norm_close, flush_close;
  logic [RW-1:0] retry_cnt;
  logic [NEV-1:0] evt_set;

  assign in_send  = (state_q == S_SEND);
  assign in_tail  = (state_q == S_TAIL);
  assign in_flush = (state_q == S_FLUSH);
  assign lb       = int_loop(cfg_fdx, cfg_loop, cfg_drt);

  // Error arbitration: underrun > collision > normal close.
  assign un_evt      = in_send & fifo_underrun;
  assign col_hit     = in_send & col_in & ~fifo_underrun;
  assign budget_gone = (retry_cnt == retry_max);
  assign lc_evt      = col_hit & late;
  assign rl_evt      = col_hit & ~late & budget_gone;
  assign retry_req   = col_hit & ~late & ~budget_gone;

  assign norm_close  = in_send & desc_sent & ~fifo_underrun & ~col_in;
  assign flush_close = in_flush & desc_valid;
  assign close_v     = norm_close | flush_close;
  assign close_idx   = desc_idx;
  assign close_last  = desc_eof;
  assign tx_start    = (state_q == S_IDLE) & desc_valid;

  always_comb begin
    evt_set        = '0;
    evt_set[EV_UN] = un_evt;
    evt_set[EV_LC] = lc_evt;
    evt_set[EV_RL] = rl_evt;
  end

  txs_slot_retry #(.SLOT_NIB(SLOT_NIB), .RW(RW)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (tx_start),
    .retry    (retry_req),
    .count_en (in_send & txen_in & nib_tick),
    .late     (late),
    .retry_cnt(retry_cnt)
  );

  txs_tail_timer #(.TAIL_NIB(TAIL_NIB)) u_tail (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (in_tail),
    .tick (nib_tick),
    .done (tail_done)
  );

  txs_event_reg #(.N(NEV)) u_evt (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (evt_set),
    .clr  (evt_clr),
    .mask (evt_mask),
    .evt  (evt),
    .irq  (irq)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (desc_valid) state_d = S_SEND;
      S_SEND: begin
        if (un_evt)                     state_d = S_TAIL;
        else if (lc_evt || rl_evt)      state_d = S_FLUSH;
        else if (norm_close && desc_eof) state_d = S_IDLE;
      end
      S_TAIL:  if (tail_done) state_d = S_FLUSH;
      S_FLUSH: if (flush_close && desc_eof) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  // Pin gating: the tail overrides the data path, loopback silences both pins.
  always_comb begin
    txd_out  = in_tail ? TAIL_NIBBLE : txd_in;
    txen_out = 1'b0;
    txer_out = 1'b0;
    if (!lb) begin
      if (in_tail) begin
        txen_out = 1'b1;
        txer_out = 1'b1;
      end else if (in_send) begin
        txen_out = txen_in;
        txer_out = txer_in;
      end
    end
  end
endmodule

// File: rtl/txs_err_seq_chk.sv
module txs_err_seq_chk
  import txs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input seq_state_e state,
  input logic       un_evt,
  input logic       lc_evt,
  input logic       rl_evt,
  input logic       retry_req,
  input logic       late,
  input logic       lb,
  input logic [2:0] evt,
  input logic       txen_out,
  input logic       txer_out
);
  p_un_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    un_evt |=> (evt[EV_UN] && state == S_TAIL));

  p_tail_marks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TAIL && !lb) |-> (txen_out && txer_out));

  p_flush_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FLUSH) |-> (!txen_out && !txer_out));

  p_retry_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req |-> !late);

  p_rl_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rl_evt |=> (evt[EV_RL] && state == S_FLUSH));

  p_lc_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lc_evt |=> (evt[EV_LC] && state == S_FLUSH));

  p_single_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({un_evt, lc_evt, rl_evt, retry_req}));

  p_loop_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    lb |-> (!txen_out && !txer_out));
endmodule

bind txs_err_seq txs_err_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .state    (state_q),
  .un_evt   (un_evt),
  .lc_evt   (lc_evt),
  .rl_evt   (rl_evt),
  .retry_req(retry_req),
  .late     (late),
  .lb       (lb),
  .evt      (evt),
  .txen_out (txen_out),
  .txer_out (txer_out)
);

// File: tb/txs_err_seq_bench.sv
module txs_err_seq_bench;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_fdx = 0, cfg_loop = 0, cfg_drt = 0;
  logic [3:0] retry_max = 4'd2;
  logic       nib_tick = 0;
  logic [3:0] txd_in = 4'h0;
  logic       txen_in = 0, txer_in = 0;
  logic       fifo_underrun = 0, col_in = 0;
  logic       desc_valid = 0;
  logic [3:0] desc_idx = 4'h0;
  logic       desc_eof = 0, desc_sent = 0;
  logic [2:0] evt_clr = 3'b0, evt_mask = 3'b0;
  logic       tx_start, retry_req, close_v, close_last, txen_out, txer_out, irq;
  logic [3:0] close_idx, txd_out;
  logic [2:0] evt;

  txs_err_seq u_txs_err_seq (
    .clk(clk), .rst_n(rst_n), .cfg_fdx(cfg_fdx), .cfg_loop(cfg_loop), .cfg_drt(cfg_drt),
    .retry_max(retry_max), .nib_tick(nib_tick), .txd_in(txd_in), .txen_in(txen_in),
    .txer_in(txer_in), .fifo_underrun(fifo_underrun), .col_in(col_in),
    .desc_valid(desc_valid), .desc_idx(desc_idx), .desc_eof(desc_eof), .desc_sent(desc_sent),
    .evt_clr(evt_clr), .evt_mask(evt_mask), .tx_start(tx_start), .retry_req(retry_req),
    .close_v(close_v), .close_idx(close_idx), .close_last(close_last), .txd_out(txd_out),
    .txen_out(txen_out), .txer_out(txer_out), .evt(evt), .irq(irq)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // Behavioural reference state: 0 idle, 1 sending, 2 tail, 3 flush.
  int m_state = 0, m_slot = 0, m_retry = 0, m_tail = 0;
  bit [2:0] m_evt = 3'b0;
  int q_idx[$];
  bit q_eof[$];
  bit hold = 0;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input int idx, input bit eof);
    q_idx.push_back(idx);
    q_eof.push_back(eof);
  endtask

  // One clock: present inputs, compare at mid-low phase, advance the model at the edge.
  task automatic step();
    bit lb, snd, eun, ecol, late, elc, erl, ertr, ecl, est, eten, eter, tdone;
    int etxd;
    bit [2:0] set;
    desc_valid = !hold && q_idx.size() > 0;
    desc_idx   = (q_idx.size() > 0) ? 4'(q_idx[0]) : 4'h0;
    desc_eof   = (q_eof.size() > 0) ? q_eof[0] : 1'b0;
    #1;
    lb   = cfg_fdx && cfg_loop && !cfg_drt;
    snd  = (m_state == 1);
    eun  = snd && fifo_underrun;
    ecol = snd && col_in && !fifo_underrun;
    late = (m_slot >= 128);
    elc  = ecol && late;
    erl  = ecol && !late && (m_retry == int'(retry_max));
    ertr = ecol && !late && (m_retry != int'(retry_max));
    ecl  = (snd && desc_sent && !fifo_underrun && !col_in) || (m_state == 3 && desc_valid);
    est  = (m_state == 0) && desc_valid;
    eten = lb ? 0 : (m_state == 2) ? 1 : snd ? txen_in : 0;
    eter = lb ? 0 : (m_state == 2) ? 1 : snd ? txer_in : 0;
    etxd = (m_state == 2) ? 15 : int'(txd_in);
    check("R2 tx_start", int'(tx_start), int'(est));
    check("R6 retry_req", int'(retry_req), int'(ertr));
    check("R3 close_v", int'(close_v), int'(ecl));
    if (ecl) begin
      check("R5 close_idx", int'(close_idx), q_idx[0]);
      check("R3 close_last", int'(close_last), int'(q_eof[0]));
    end
    check("R13 txen_out", int'(txen_out), int'(eten));
    check("R13 txer_out", int'(txer_out), int'(eter));
    check("R4 txd_out", int'(txd_out), etxd);
    check("R11 evt", int'(evt), int'(m_evt));
    check("R12 irq", int'(irq), int'(|(m_evt & evt_mask)));
    @(posedge clk);
    tdone = (m_state == 2) && nib_tick && (m_tail == 7);
    set = {erl, elc, eun};
    m_evt = (m_evt & ~evt_clr) | set;
    if (est || ertr) m_slot = 0;
    else if (snd && txen_in && nib_tick && m_slot < 128) m_slot++;
    if (est) m_retry = 0;
    else if (ertr) m_retry++;
    m_tail = (m_state == 2) ? (nib_tick ? m_tail + 1 : m_tail) : 0;
    case (m_state)
      0: if (desc_valid) m_state = 1;
      1: if (eun) m_state = 2;
         else if (elc || erl) m_state = 3;
         else if (ecl && desc_eof) m_state = 0;
      2: if (tdone) m_state = 3;
      default: if (ecl && desc_eof) m_state = 0;
    endcase
    if (ecl) begin
      void'(q_idx.pop_front());
      void'(q_eof.pop_front());
    end
    @(negedge clk);
    fifo_underrun = 0; col_in = 0; desc_sent = 0; evt_clr = 3'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      txd_in = 4'(i);
      step();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    txen_in = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, idle masks data-path enable
    #1;
    check("R1 evt", int'(evt), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 txen_out", int'(txen_out), 0);
    check("R1 close_v", int'(close_v), 0);
    txen_in = 0;
    @(negedge clk);
    // R10: errors while idle change nothing
    fifo_underrun = 1; col_in = 1; step();
    run(2);

    // R2, R3: two-descriptor frame finishes normally
    nib_tick = 1;
    push(1, 0); push(2, 1);
    step();
    txen_in = 1; run(5);
    desc_sent = 1; step();
    run(3);
    desc_sent = 1; step();
    txen_in = 0; run(2);

    // R6, R7: retries then retry limit, R9 collision beats desc_sent
    push(3, 1);
    step();
    txen_in = 1; run(4);
    col_in = 1; desc_sent = 1; step();
    run(3);
    col_in = 1; step();
    run(2);
    evt_mask = 3'b100;
    col_in = 1; step();
    txen_in = 0;
    run(3);

    // R8: late collision after 128 nibbles, flush with a gap, R12 mask
    push(4, 0); push(5, 1);
    step();
    txen_in = 1; run(127);
    col_in = 1; step();      // slot count 127: retry, window restarts
    run(130);
    col_in = 1; step();      // slot count saturated at 128: late
    txen_in = 0;
    hold = 1; fifo_underrun = 1; col_in = 1; step(); hold = 0;
    run(3);
    evt_mask = 3'b010; run(1);

    // R11: clear all, then clear UN in the cycle underrun fires again
    evt_clr = 3'b111; step();
    push(6, 0); push(7, 0); push(8, 1);
    step();
    txen_in = 1; run(3);
    // R9: underrun and collision together give UN only
    fifo_underrun = 1; col_in = 1; evt_clr = 3'b001; step();
    txen_in = 0;
    // R4: tail with a slow nibble tick; R10 errors inside the tail ignored
    for (int i = 0; i < 20; i++) begin
      nib_tick = i[0];
      if (i == 5) begin fifo_underrun = 1; col_in = 1; end
      step();
    end
    nib_tick = 1;
    run(4);

    // R13: internal loopback through a full tail, then DRT set disables gating
    cfg_fdx = 1; cfg_loop = 1; cfg_drt = 0; evt_mask = 3'b111;
    push(9, 1);
    step();
    txen_in = 1; txer_in = 1; run(3);
    fifo_underrun = 1; step();
    run(12);
    cfg_drt = 1;
    push(10, 1);
    step();
    run(3);
    desc_sent = 1; step();
    txen_in = 0; txer_in = 0;
    run(3);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule